// File: doc/BRIEF.md
# Trace Sample Word Packer

The packer takes one trace sample per clock from a processor trace port and packs consecutive samples into 32-bit words for a capture memory. A sample has a 3-bit pipeline status, a packet field and a sync flag. The width of the packet field is set by the port-width mode, and the mode also sets how many samples share one word. A trigger flag on a sample is folded into the word by a fixed substitution. A decoder can undo that substitution later, so no extra storage bit is needed.

A word is presented together with a one-cycle write strobe as soon as its last slot fills. The caller can force out a partly filled word with the flush input, for example at the end of a capture. The empty output shows when nothing is pending, and the mode input is only sampled while the packer is empty. Memory addressing and decoding are left to the blocks around it.

Top module: `trc_word_packer`

## Requirements
- R1: With mode_i = 0 (4-bit port), three samples fill one word in 8-bit slots at bits 0, 8 and 16. Within each slot, bits 2:0 hold the status, bits 6:3 hold packet bits 3:0 and bit 7 holds the sync flag.
- R2: With mode_i = 1 (8-bit port), two samples fill one word in 12-bit slots at bits 0 and 12. Within each slot, bits 2:0 hold the status, bits 10:3 hold packet bits 7:0 and bit 11 holds the sync flag.
- R3: With mode_i = 2 or 3 (16-bit port), each sample forms a word on its own. Bits 2:0 hold the status, bits 18:3 hold the packet and bit 19 holds the sync flag.
- R4: For a sample with the trigger flag set, the status field carries the code TRIG_CODE (default 3'b110). Packet bits 2:0 are replaced by the true status, and the packet bits above them are kept.
- R5: A word is output with word_we_o high for exactly one cycle, starting in the cycle after the clock edge that accepts the sample filling its last slot. Slots fill lowest first, in the order samples arrive. Word bits above the last slot are zero, and word_o is zero whenever word_we_o is low.
- R6: A flush_i pulse while samples are pending outputs the partial word, with its unused slots zeroed, one cycle later. A sample accepted on the flush cycle is included in that word. A flush while nothing is pending has no effect.
- R7: empty_o is high exactly when no sample is pending. After reset, empty_o is high and word_we_o is low.
- R8: mode_i is taken only while empty_o is high. A change made while samples are pending does not alter the layout until the pending word has been output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Port width: 0 = 4-bit, 1 = 8-bit, 2/3 = 16-bit |
| smp_valid_i | input | 1 | A sample is present this cycle |
| smp_stat_i | input | 3 | Pipeline status of the sample |
| smp_pkt_i | input | 16 | Packet field; only the low port-width bits are used |
| smp_sync_i | input | 1 | Sync flag of the sample |
| smp_trig_i | input | 1 | Sample is the trigger cycle |
| flush_i | input | 1 | Output any partial word |
| word_o | output | 32 | Packed word |
| word_we_o | output | 1 | Write strobe for word_o |
| empty_o | output | 1 | No sample pending |

## Verification
The bench targets a flush that arrives in the same cycle as a sample. A design that flushes before placing the sample would lose it or leave it stranded in a new word. It changes mode_i in the middle of a word: a design that reacts to the change at once would emit a word that mixes two slot widths at the wrong offsets. Trigger samples in every mode catch a swapped status/packet substitution or lost upper packet bits. Flush on an empty packer and long random runs with idle gaps catch spurious strobes and stale bits left from an earlier word.

// File: rtl/trc_pack_pkg.sv
`timescale 1ns/1ps
package trc_pack_pkg;
  localparam int STAT_W    = 3;
  localparam int PKT_W     = 16;
  localparam int SLOT_W    = STAT_W + PKT_W + 1;
  localparam int WORD_W    = 32;
  localparam int SLOTS_MAX = 3;
  localparam int CNT_W     = $clog2(SLOTS_MAX + 1);

  typedef enum logic [1:0] {
    MODE_P4  = 2'd0,
    MODE_P8  = 2'd1,
    MODE_P16 = 2'd2,
    MODE_P16X = 2'd3
  } port_mode_e;

  function automatic logic [CNT_W-1:0] slots_of(port_mode_e m);
    case (m)
      MODE_P4: return CNT_W'(3);
      MODE_P8: return CNT_W'(2);
      default: return CNT_W'(1);
    endcase
  endfunction

  function automatic int slot_w_of(port_mode_e m);
    case (m)
      MODE_P4: return 8;
      MODE_P8: return 12;
      default: return SLOT_W;
    endcase
  endfunction
endpackage

// File: rtl/trc_slot_fmt.sv
`timescale 1ns/1ps
module trc_slot_fmt
  import trc_pack_pkg::*;
#(
  parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
  input  port_mode_e          mode_i,
  input  logic [STAT_W-1:0]   stat_i,
  input  logic [PKT_W-1:0]    pkt_i,
  input  logic                sync_i,
  input  logic                trig_i,
  output logic [SLOT_W-1:0]   slot_o
);
  logic [STAT_W-1:0] stat_eff;
  logic [PKT_W-1:0]  pkt_eff;

  // trigger: status field carries the code, true status moves into packet
  always_comb begin
    stat_eff = trig_i ? TRIG_CODE : stat_i;
    pkt_eff  = trig_i ? {pkt_i[PKT_W-1:STAT_W], stat_i} : pkt_i;
  end

  always_comb begin
    case (mode_i)
      MODE_P4: slot_o = {{(SLOT_W-8){1'b0}}, sync_i, pkt_eff[3:0], stat_eff};
      MODE_P8: slot_o = {{(SLOT_W-12){1'b0}}, sync_i, pkt_eff[7:0], stat_eff};
      default: slot_o = {sync_i, pkt_eff, stat_eff};
    endcase
  end
endmodule

// File: rtl/trc_slot_place.sv
`timescale 1ns/1ps
module trc_slot_place
  import trc_pack_pkg::*;
(
  input  port_mode_e          mode_i,
  input  logic                valid_i,
  input  logic [CNT_W-1:0]    idx_i,
  input  logic [SLOT_W-1:0]   slot_i,
  output logic [WORD_W-1:0]   word_o
);
  logic [WORD_W-1:0] lane_word [SLOTS_MAX];

  for (genvar g = 0; g < SLOTS_MAX; g++) begin : g_lane
    always_comb begin
      lane_word[g] = '0;
      if (valid_i && idx_i == CNT_W'(g))
        lane_word[g] = WORD_W'(slot_i) << (g * slot_w_of(mode_i));
    end
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k < SLOTS_MAX; k++) word_o = word_o | lane_word[k];
  end
endmodule

// File: rtl/trc_pack_ctrl.sv
`timescale 1ns/1ps
module trc_pack_ctrl
  import trc_pack_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             valid_i,
  input  logic             flush_i,
  output port_mode_e       mode_eff_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             emit_o,
  output logic             empty_o
);
  port_mode_e       mode_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc;

  assign empty_o    = (cnt_q == '0);
  assign mode_eff_o = empty_o ? port_mode_e'(mode_i) : mode_q;
  assign cnt_o      = cnt_q;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(valid_i);
    emit_o  = (cnt_inc == slots_of(mode_eff_o)) || (flush_i && cnt_inc != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_P4;
    end else begin
      cnt_q  <= emit_o ? '0 : cnt_inc;
      mode_q <= mode_eff_o;
    end
  end
endmodule

// File: rtl/trc_word_packer.sv
`timescale 1ns/1ps
module trc_word_packer
  import trc_pack_pkg::*;
#(
  parameter logic [2:0] TRIG_CODE = 3'b110
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  mode_i,
  input  logic        smp_valid_i,
  input  logic [2:0]  smp_stat_i,
  input  logic [15:0] smp_pkt_i,
  input  logic        smp_sync_i,
  input  logic        smp_trig_i,
  input  logic        flush_i,
  output logic [31:0] word_o,
  output logic        word_we_o,
  output logic        empty_o
);
  port_mode_e        mode_eff;
  logic [CNT_W-1:0]  cnt;
  logic              emit;
  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] placed, acc_q, acc_d, word_q;
  logic              we_q;

  trc_pack_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .valid_i    (smp_valid_i),
    .flush_i    (flush_i),
    .mode_eff_o (mode_eff),
    .cnt_o      (cnt),
    .emit_o     (emit),
    .empty_o    (empty_o)
  );

  trc_slot_fmt #(.TRIG_CODE(TRIG_CODE)) i_fmt (
    .mode_i (mode_eff),
    .stat_i (smp_stat_i),
    .pkt_i  (smp_pkt_i),
    .sync_i (smp_sync_i),
    .trig_i (smp_trig_i),
    .slot_o (slot)
  );

  trc_slot_place i_place (
    .mode_i  (mode_eff),
    .valid_i (smp_valid_i),
    .idx_i   (cnt),
    .slot_i  (slot),
    .word_o  (placed)
  );

  assign acc_d = acc_q | placed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      word_q <= '0;
      we_q   <= 1'b0;
    end else begin
      acc_q  <= emit ? '0 : acc_d;
      word_q <= emit ? acc_d : '0;
      we_q   <= emit;
    end
  end

  assign word_o    = word_q;
  assign word_we_o = we_q;
endmodule

// File: rtl/trc_word_packer_chk.sv
`timescale 1ns/1ps
module trc_word_packer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  mode_i,
  input logic        smp_valid_i,
  input logic        flush_i,
  input logic [31:0] word_o,
  input logic        word_we_o,
  input logic        empty_o
);
  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_we_o |-> word_o == 32'h0);

  a_r5_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_we_o |-> word_o[31:24] == 8'h0);

  a_r7_emit_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_we_o |-> empty_o);

  a_r6_flush_emits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !empty_o) |=> word_we_o);

  a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !smp_valid_i) |=> !word_we_o);

  a_r3_single_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && smp_valid_i && mode_i >= 2'd2) |=> word_we_o);
endmodule

bind trc_word_packer trc_word_packer_chk i_chk (.*);

// File: tb/test_trc_word_packer.sv
`timescale 1ns/1ps
module test_trc_word_packer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        smp_valid_i = 1'b0;
  logic [2:0]  smp_stat_i = '0;
  logic [15:0] smp_pkt_i = '0;
  logic        smp_sync_i = 1'b0;
  logic        smp_trig_i = 1'b0;
  logic        flush_i = 1'b0;
  logic [31:0] word_o;
  logic        word_we_o;
  logic        empty_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit running = 1'b0;
  string cur_req = "R7";

  // reference model state
  int          m_cnt = 0, m_mode = 0;
  logic [31:0] m_acc = '0, exp_word = '0;
  logic        exp_we = 1'b0;

  always #4 clk_i = ~clk_i;

  trc_word_packer i_trc_word_packer (.*);

  function automatic logic [31:0] mk(int md, logic [2:0] st, logic [15:0] pk,
                                     logic sy, logic tg);
    int pw = (md == 0) ? 4 : (md == 1) ? 8 : 16;
    logic [31:0] p = 32'(pk) & ((32'd1 << pw) - 1);
    logic [2:0] s = st;
    if (tg) begin
      s = 3'b110;
      p = (p & ~32'd7) | 32'(st);
    end
    return 32'(s) | (p << 3) | (32'(sy) << (3 + pw));
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_mode = 0; m_acc = '0; exp_we = 0; exp_word = '0;
    end else begin
      int ns, w;
      if (m_cnt == 0) m_mode = (mode_i == 2'd3) ? 2 : int'(mode_i);
      ns = (m_mode == 0) ? 3 : (m_mode == 1) ? 2 : 1;
      w  = (m_mode == 0) ? 8 : (m_mode == 1) ? 12 : 20;
      exp_we = 0; exp_word = '0;
      if (smp_valid_i) begin
        m_acc = m_acc | (mk(m_mode, smp_stat_i, smp_pkt_i, smp_sync_i, smp_trig_i) << (m_cnt * w));
        m_cnt++;
      end
      if (m_cnt == ns || (flush_i && m_cnt > 0)) begin
        exp_we = 1; exp_word = m_acc; m_acc = '0; m_cnt = 0;
      end
    end
  end

  always @(negedge clk_i) begin
    cyc++;
    if (running) begin
      n_chk++;
      if (word_we_o !== exp_we || word_o !== exp_word || empty_o !== (m_cnt == 0)) begin
        n_fail++;
        $display("FAIL %s: we=%0b word=%h empty=%0b, expected we=%0b word=%h empty=%0b",
                 cur_req, word_we_o, word_o, empty_o, exp_we, exp_word, m_cnt == 0);
      end
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: cycle=%0d, expected end before 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic smp(logic [2:0] st, logic [15:0] pk, logic sy, logic tg, logic fl = 0);
    smp_valid_i = 1; smp_stat_i = st; smp_pkt_i = pk; smp_sync_i = sy; smp_trig_i = tg;
    flush_i = fl;
    @(negedge clk_i);
    smp_valid_i = 0; smp_trig_i = 0; flush_i = 0;
  endtask

  task automatic idle(int n, logic fl = 0);
    flush_i = fl;
    repeat (n) @(negedge clk_i);
    flush_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R7 reset state
    n_chk++;
    if (empty_o !== 1'b1 || word_we_o !== 1'b0 || word_o !== 32'h0) begin
      n_fail++;
      $display("FAIL R7: reset empty=%0b we=%0b word=%h, expected 1 0 0", empty_o, word_we_o, word_o);
    end
    rst_ni = 1; running = 1;
    @(negedge clk_i);

    cur_req = "R1"; mode_i = 0;
    smp(3'd5, 16'hFFFA, 1, 0); smp(3'd1, 16'h0003, 0, 0); idle(1); smp(3'd7, 16'h000F, 1, 0);
    idle(2);
    cur_req = "R2"; mode_i = 1;
    smp(3'd2, 16'hA5C3, 1, 0); smp(3'd6, 16'h005A, 0, 0); idle(2);
    cur_req = "R3"; mode_i = 2;
    smp(3'd4, 16'hBEEF, 1, 0); smp(3'd3, 16'h1234, 0, 0); mode_i = 3;
    smp(3'd1, 16'h8001, 1, 0); idle(2);
    cur_req = "R4";
    for (int m = 0; m < 3; m++) begin
      mode_i = 2'(m);
      for (int k = 0; k < 3; k++) smp(3'(k + 1), 16'hFFF8 | 16'(k), 1'(k), 1);
      idle(2);
    end
    cur_req = "R5"; mode_i = 0;
    for (int k = 0; k < 9; k++) smp(3'(k), 16'(k * 7), 1'(k & 1), 0);
    idle(2);
    cur_req = "R6"; mode_i = 1;
    smp(3'd3, 16'h00C3, 1, 0); idle(1, 1); idle(1, 1); idle(1);
    mode_i = 0;
    smp(3'd2, 16'h0009, 0, 0); smp(3'd5, 16'h0006, 1, 0, 1); idle(2);
    cur_req = "R8"; mode_i = 0;
    smp(3'd1, 16'h000A, 1, 0); mode_i = 2;
    smp(3'd2, 16'h000B, 0, 0); mode_i = 1; smp(3'd3, 16'h000C, 1, 0);
    mode_i = 2; smp(3'd4, 16'h1357, 1, 0); idle(2);
    cur_req = "R5";
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 15) == 0) mode_i = 2'($urandom);
      smp_valid_i = ($urandom_range(0, 3) != 0);
      smp_stat_i = 3'($urandom); smp_pkt_i = 16'($urandom);
      smp_sync_i = 1'($urandom); smp_trig_i = ($urandom_range(0, 7) == 0);
      flush_i = ($urandom_range(0, 15) == 0);
      @(negedge clk_i);
    end
    smp_valid_i = 0; flush_i = 0; smp_trig_i = 0;
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule